// File: doc/BRIEF.md
# Bit-Serial Table-Based PID Controller

The block computes one PID control word per sample. It uses no multipliers. Each of the three terms is produced by a small constant table and a shift-accumulate lane. The table is addressed by one bit of each operand per clock, least significant bit first. The lane adds the table entry at weight 2^j. On the top bit it subtracts the entry instead, because the operands are two's complement.

The proportional term applies only a weighted fraction of the setpoint. The integral term builds on the error of the previous sample. The derivative term is first-order filtered and sees only the measurement, so a setpoint step produces no derivative kick.

A sample starts on a strobe. It takes DATA_W clocks of serial accumulation, then one update clock that refreshes the stored history and the output. The table constants are derived at elaboration from real-valued gain, weight, time-constant and filter parameters. Each constant is rounded to the nearest step of 2^-FRAC_W.

Top module: `pid_da_top`

## Requirements
- R1: After reset `ctrl_o` is 0 and `valid_o` is 0. The stored history (previous setpoint, previous measurement, derivative state and integral) is zero.
- R2: A strobe accepted at a clock edge raises `valid_o` after the (DATA_W+1)-th following edge, for exactly one clock. The new `ctrl_o` appears at the same edge.
- R3: The proportional part is KB*uc - KP*y in Q.FRAC_W. With the default parameters KB = 256 and KP = 512.
- R4: The integral is I(k) = I(k-1) + KI*(uc(k-1) - y(k-1)), with KI = 128 by default. For the first sample after reset the previous values are zero.
- R5: The derivative part is A*Ds - KD*(y(k) - y(k-1)), with A = 128 and KD = 512 by default. Ds is the stored derivative state. The setpoint does not enter this term.
- R6: After each sample the derivative state becomes floor(D/2^FRAC_W), saturated to the signed DATA_W range.
- R7: `ctrl_o` is floor((P+I+D)/2^FRAC_W), saturated to the signed OUT_W range (-512..511 by default).
- R8: A strobe that arrives while a sample is in progress is ignored. Setpoint and measurement are sampled only at the accepting edge.
- R9: Setpoint and measurement are DATA_W-bit two's complement values. The full range, including -2^(DATA_W-1), is handled.
- R10: `ctrl_o` holds its value between valid pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| strobe_i | input | 1 | Starts a sample when idle |
| setpoint_i | input | DATA_W | Setpoint, two's complement |
| meas_i | input | DATA_W | Process measurement, two's complement |
| ctrl_o | output | OUT_W | Control word, two's complement |
| valid_o | output | 1 | One-clock pulse when ctrl_o is new |

## Verification
Every result is due DATA_W+1 edges after the accepting edge. The bench counts exactly that many rising edges before it checks `valid_o` and `ctrl_o`. It samples on the falling edge in between, and checks one edge later that the pulse has dropped.

Halfway through each sample it confirms that `valid_o` is low and that `ctrl_o` still holds the previous word. As soon as the accepting edge has passed, it drives garbage onto the inputs. In one scenario it also pulses the strobe mid-sample, then watches for two full sample lengths that no extra pulse appears. The expected words come from an integer model of R3 to R7 carried across the sample sequence.

// File: rtl/pid_da_pkg.sv
package pid_da_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_UPD} seq_state_e;

  // real coefficient -> nearest fixed-point integer with frac fractional bits
  function automatic longint fix_round(input real x, input int unsigned frac);
    real scaled;
    scaled = x * (2.0 ** frac);
    if (scaled >= 0.0) return longint'($rtoi(scaled + 0.5));
    else               return -longint'($rtoi(0.5 - scaled));
  endfunction

endpackage

// File: rtl/pid_da_seq.sv
module pid_da_seq #(
  parameter int unsigned DATA_W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  output logic load_o,
  output logic en_o,
  output logic last_o,
  output logic upd_o,
  output logic busy_o
);
  import pid_da_pkg::*;

  localparam int unsigned CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;

  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;

  assign load_o = (state_q == ST_IDLE) && strobe_i;
  assign en_o   = (state_q == ST_RUN);
  assign last_o = en_o && (cnt_q == CNT_W'(DATA_W - 1));
  assign upd_o  = (state_q == ST_UPD);
  assign busy_o = (state_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (strobe_i) begin
          state_q <= ST_RUN;
          cnt_q   <= '0;
        end
        ST_RUN: begin
          cnt_q <= cnt_q + 1'b1;
          if (last_o) state_q <= ST_UPD;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pid_da_lane.sv
module pid_da_lane #(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned COEF_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ACC_W  = COEF_W + DATA_W + 2,
  parameter logic signed [COEF_W-1:0] TAB [2**ADDR_W] = '{default: '0}
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clr_i,
  input  logic                     en_i,
  input  logic                     last_i,
  input  logic [ADDR_W-1:0]        addr_i,
  output logic signed [ACC_W-1:0]  acc_o
);

  logic signed [ACC_W-1:0] ent_ext, term, sum;

  // entry aligned above the operand width; right shifts bring it to weight 2^j
  assign ent_ext = ACC_W'(TAB[addr_i]);
  assign term    = ent_ext <<< DATA_W;
  assign sum     = last_i ? (acc_o - term) : (acc_o + term);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_o <= '0;
    else if (clr_i) acc_o <= '0;
    else if (en_i)  acc_o <= sum >>> 1;
  end

endmodule

// File: rtl/pid_da_top.sv
module pid_da_top #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned OUT_W     = 10,
  parameter int unsigned FRAC_W    = 8,
  parameter int unsigned COEF_W    = 16,
  parameter real         K_GAIN    = 2.0,
  parameter real         SP_WEIGHT = 0.5,
  parameter real         T_SAMP    = 1.0,
  parameter real         T_INT     = 4.0,
  parameter real         T_DER     = 2.0,
  parameter real         N_FILT    = 2.0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     strobe_i,
  input  logic signed [DATA_W-1:0] setpoint_i,
  input  logic signed [DATA_W-1:0] meas_i,
  output logic signed [OUT_W-1:0]  ctrl_o,
  output logic                     valid_o
);
  import pid_da_pkg::*;

  localparam int unsigned ACC_W = COEF_W + DATA_W + 2;
  localparam int unsigned I_W   = ACC_W + 4;
  localparam int unsigned SUM_W = I_W + 2;
  localparam int unsigned N_OP  = 5;  // uc, y, uc_prev, y_prev, d_state

  localparam real    DEN  = T_DER + N_FILT * T_SAMP;
  localparam longint KB_F = fix_round(K_GAIN * SP_WEIGHT, FRAC_W);
  localparam longint KP_F = fix_round(K_GAIN, FRAC_W);
  localparam longint KI_F = fix_round(K_GAIN * T_SAMP / T_INT, FRAC_W);
  localparam longint A_F  = fix_round(T_DER / DEN, FRAC_W);
  localparam longint KD_F = fix_round(K_GAIN * T_DER * N_FILT / DEN, FRAC_W);

  // P address {uc,y}; I address {uc_prev,y_prev}; D address {d_state,y,y_prev}
  localparam logic signed [COEF_W-1:0] P_TAB [4] = '{
    COEF_W'(0), COEF_W'(-KP_F), COEF_W'(KB_F), COEF_W'(KB_F - KP_F)};
  localparam logic signed [COEF_W-1:0] I_TAB [4] = '{
    COEF_W'(0), COEF_W'(-KI_F), COEF_W'(KI_F), COEF_W'(0)};
  localparam logic signed [COEF_W-1:0] D_TAB [8] = '{
    COEF_W'(0), COEF_W'(KD_F), COEF_W'(-KD_F), COEF_W'(0),
    COEF_W'(A_F), COEF_W'(A_F + KD_F), COEF_W'(A_F - KD_F), COEF_W'(A_F)};

  localparam logic signed [SUM_W-1:0] OUT_MAX = SUM_W'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
  localparam logic signed [SUM_W-1:0] OUT_MIN = SUM_W'(-(64'sd1 <<< (OUT_W - 1)));
  localparam logic signed [ACC_W-1:0] DS_MAX  = ACC_W'((64'sd1 <<< (DATA_W - 1)) - 64'sd1);
  localparam logic signed [ACC_W-1:0] DS_MIN  = ACC_W'(-(64'sd1 <<< (DATA_W - 1)));

  logic load, en, last, upd, busy;

  logic signed [DATA_W-1:0] ucp_q, yp_q, ds_q, uc_cur_q, y_cur_q;
  logic signed [I_W-1:0]    i_q;
  logic [DATA_W-1:0]        op_ld [N_OP];
  logic [DATA_W-1:0]        op_sr [N_OP];
  logic signed [ACC_W-1:0]  acc_p, acc_i, acc_d;

  pid_da_seq #(.DATA_W(DATA_W)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .strobe_i(strobe_i),
    .load_o(load), .en_o(en), .last_o(last), .upd_o(upd), .busy_o(busy)
  );

  always_comb begin
    op_ld[0] = setpoint_i;
    op_ld[1] = meas_i;
    op_ld[2] = ucp_q;
    op_ld[3] = yp_q;
    op_ld[4] = ds_q;
  end

  for (genvar g = 0; g < N_OP; g++) begin : g_op
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   op_sr[g] <= '0;
      else if (load) op_sr[g] <= op_ld[g];
      else if (en)   op_sr[g] <= op_sr[g] >> 1;
    end
  end

  pid_da_lane #(.ADDR_W(2), .COEF_W(COEF_W), .DATA_W(DATA_W), .ACC_W(ACC_W), .TAB(P_TAB)) u_lane_p (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(load), .en_i(en), .last_i(last),
    .addr_i({op_sr[0][0], op_sr[1][0]}), .acc_o(acc_p)
  );
  pid_da_lane #(.ADDR_W(2), .COEF_W(COEF_W), .DATA_W(DATA_W), .ACC_W(ACC_W), .TAB(I_TAB)) u_lane_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(load), .en_i(en), .last_i(last),
    .addr_i({op_sr[2][0], op_sr[3][0]}), .acc_o(acc_i)
  );
  pid_da_lane #(.ADDR_W(3), .COEF_W(COEF_W), .DATA_W(DATA_W), .ACC_W(ACC_W), .TAB(D_TAB)) u_lane_d (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(load), .en_i(en), .last_i(last),
    .addr_i({op_sr[4][0], op_sr[1][0], op_sr[3][0]}), .acc_o(acc_d)
  );

  logic signed [I_W-1:0]    i_next;
  logic signed [SUM_W-1:0]  total, total_sh, ctrl_sat;
  logic signed [ACC_W-1:0]  d_sh, ds_sat;

  always_comb begin
    i_next   = i_q + I_W'(acc_i);
    total    = SUM_W'(acc_p) + SUM_W'(i_next) + SUM_W'(acc_d);
    total_sh = total >>> FRAC_W;
    d_sh     = acc_d >>> FRAC_W;
    if (total_sh > OUT_MAX)      ctrl_sat = OUT_MAX;
    else if (total_sh < OUT_MIN) ctrl_sat = OUT_MIN;
    else                         ctrl_sat = total_sh;
    if (d_sh > DS_MAX)           ds_sat = DS_MAX;
    else if (d_sh < DS_MIN)      ds_sat = DS_MIN;
    else                         ds_sat = d_sh;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      uc_cur_q <= '0;
      y_cur_q  <= '0;
      ucp_q    <= '0;
      yp_q     <= '0;
      ds_q     <= '0;
      i_q      <= '0;
      ctrl_o   <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= upd;
      if (load) begin
        uc_cur_q <= setpoint_i;
        y_cur_q  <= meas_i;
      end
      if (upd) begin
        ucp_q  <= uc_cur_q;
        yp_q   <= y_cur_q;
        ds_q   <= DATA_W'(ds_sat);
        i_q    <= i_next;
        ctrl_o <= OUT_W'(ctrl_sat);
      end
    end
  end

endmodule

// File: rtl/pid_da_chk.sv
module pid_da_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OUT_W  = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             strobe_i,
  input logic             busy_i,
  input logic             valid_i,
  input logic [OUT_W-1:0] ctrl_i
);

  localparam int unsigned CW = $clog2(DATA_W + 2) + 1;

  logic          trk;
  logic [CW-1:0] cnt;
  logic          fin;

  assign fin = trk && (cnt == CW'(DATA_W + 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trk <= 1'b0;
      cnt <= '0;
    end else if (!trk && strobe_i) begin
      trk <= 1'b1;
      cnt <= CW'(1);
    end else if (trk) begin
      cnt <= cnt + 1'b1;
      if (fin) trk <= 1'b0;
    end
  end

  AST_BUSY_TRACKS: assert property (@(posedge clk_i) disable iff (!rst_ni) busy_i == trk);                 // R8
  AST_VALID_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni) fin |=> valid_i);             // R2
  AST_VALID_ONLY_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni) !fin |=> !valid_i);      // R2
  AST_HOLD_BETWEEN: assert property (@(posedge clk_i) disable iff (!rst_ni) !fin |=> $stable(ctrl_i));    // R10

endmodule

bind pid_da_top pid_da_chk #(.DATA_W(DATA_W), .OUT_W(OUT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .strobe_i(strobe_i), .busy_i(busy),
  .valid_i(valid_o), .ctrl_i(ctrl_o)
);

// File: tb/pid_da_top_tb_top.sv
module pid_da_top_tb_top;

  localparam int unsigned DATA_W = 8;
  localparam int unsigned OUT_W  = 10;
  localparam time         CLK_PERIOD = 10ns;
  localparam longint KB = 256, KP = 512, KI = 128, A = 128, KD = 512;

  logic clk = 1'b0, rst_n = 1'b0, strobe = 1'b0;
  logic signed [DATA_W-1:0] sp = '0, meas = '0;
  logic signed [OUT_W-1:0]  ctrl;
  logic                     valid;

  int n_chk = 0, n_fail = 0;
  longint m_ucp = 0, m_yp = 0, m_ds = 0, m_i = 0, m_out = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pid_da_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .strobe_i(strobe),
    .setpoint_i(sp), .meas_i(meas), .ctrl_o(ctrl), .valid_o(valid)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint sat(input longint v, input int unsigned w);
    longint hi, lo;
    hi = (64'sd1 <<< (w - 1)) - 1;
    lo = -(64'sd1 <<< (w - 1));
    return (v > hi) ? hi : ((v < lo) ? lo : v);
  endfunction

  // one sample; glitch pulses strobe mid-sample with other values (R8)
  task automatic run_sample(input longint uc, input longint y, input bit glitch, input string tag);
    longint p, inew, d, sum, exp_out, prev;
    prev = m_out;
    p    = KB * uc - KP * y;                      // R3
    inew = m_i + KI * (m_ucp - m_yp);             // R4
    d    = A * m_ds - KD * (y - m_yp);            // R5
    sum  = p + inew + d;
    exp_out = sat(sum >>> 8, OUT_W);              // R7
    @(negedge clk);
    strobe = 1'b1; sp = DATA_W'(uc); meas = DATA_W'(y);
    @(posedge clk);
    @(negedge clk);
    strobe = 1'b0; sp = ~sp; meas = meas ^ 8'h5a;
    for (int k = 1; k <= DATA_W; k++) begin
      @(posedge clk);
      @(negedge clk);
      strobe = 1'b0;
      if (glitch && k == 2) begin
        strobe = 1'b1; sp = 8'sd99; meas = -8'sd77;
      end
      if (k == DATA_W / 2) begin
        chk(valid == 1'b0, {"R2 busy-low ", tag}, valid, 0);
        chk($signed(ctrl) == prev, {"R10 hold ", tag}, $signed(ctrl), prev);
      end
    end
    @(posedge clk);
    @(negedge clk);
    chk(valid == 1'b1, {"R2 pulse ", tag}, valid, 1);
    chk($signed(ctrl) == exp_out, {"R7 value ", tag}, $signed(ctrl), exp_out);
    @(posedge clk);
    @(negedge clk);
    chk(valid == 1'b0, {"R2 one-shot ", tag}, valid, 0);
    m_i = inew;
    m_ds = sat(d >>> 8, DATA_W);                  // R6
    m_ucp = uc; m_yp = y; m_out = exp_out;
  endtask

  task automatic t_reset();
    chk(valid == 1'b0, "R1 valid", valid, 0);
    chk(ctrl == '0, "R1 ctrl", $signed(ctrl), 0);
  endtask

  task automatic t_basic();
    run_sample(10, 4, 1'b0, "basic-first");       // R3 R4 R5 with zero history
    run_sample(10, 4, 1'b0, "basic-repeat");      // R4 integral, R6 state carry
  endtask

  task automatic t_setpoint_step();
    run_sample(60, 4, 1'b0, "sp-step");           // R5 no derivative kick
    run_sample(-40, 4, 1'b0, "sp-neg");
  endtask

  task automatic t_full_range();
    run_sample(-128, 127, 1'b0, "range-a");       // R9
    run_sample(127, -128, 1'b0, "range-b");       // R7 saturation high, R6 state clip
    run_sample(-128, 127, 1'b0, "range-c");       // R7 saturation low
  endtask

  task automatic t_busy_ignore();
    bit extra;
    run_sample(5, -3, 1'b1, "busy-glitch");       // R8
    extra = 1'b0;
    for (int k = 0; k < 2 * (DATA_W + 2); k++) begin
      @(negedge clk);
      if (valid) extra = 1'b1;
    end
    chk(extra == 1'b0, "R8 no extra pulse", extra, 0);
    run_sample(5, -3, 1'b0, "busy-after");        // R8 history untouched by glitch
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_setpoint_step();
    t_full_range();
    t_busy_ignore();
    run_sample(0, 0, 1'b0, "settle");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule